// File: doc/BRIEF.md
# Renamed Dual-Bank Register File

This block is the general register storage of a small 8-bit processor core. It keeps two copies of the accumulator/flag pair and two copies of the BC pair. It keeps four interchangeable storage pairs that take the DE and HL roles, two per bank. It also holds the IX, IY and SP pairs and a hidden WZ scratch pair. Every pair is two independent byte halves. Bits 7:0 of a 16-bit value form the low half and bits 15:8 form the high half.

Logical names reach physical storage through four rename bits: one for the accumulator/flag pair, one for the bank, and one DE/HL bit for each bank. An exchange does not copy any data. It flips a rename bit on the rising edge of its strobe, so each exchange finishes in a single cycle. Reads are combinational under the mapping in force in the current cycle. Writes land on the next clock edge.

Top module: `regfile_rename`

## Requirements
- R1: While reset is asserted, and after it is released, all four rename bits are zero and every physical half holds zero, so every read returns 0x0000.
- R2: With `wrLo` set, only the low half of the selected pair takes `wrData[7:0]`. With `wrHi` set, only the high half takes `wrData[15:8]`. With both set, the full 16-bit value is stored in one cycle and is visible on `rdHi`/`rdLo` in the following cycle.
- R3: With `internalAcc` low, `pairSel` decodes as 000 BC, 001 DE, 010 HL, 011 AF, 100 IX, 101 IY and 110 SP. Code 111 selects nothing: it reads 0x0000 and its writes change no register.
- R4: With `internalAcc` high, the WZ pair is selected whatever `pairSel` holds. No code with `internalAcc` low reads or writes WZ.
- R5: A rising edge on `exAf` switches AF to the other physical AF pair. Flipping it again brings back the original contents.
- R6: A rising edge on `exBank` swaps BC, DE and HL together with the other bank. AF, IX, IY and SP are unaffected.
- R7: A rising edge on `exDeHl` swaps DE and HL in the active bank only. The other bank keeps its own DE/HL assignment across bank swaps.
- R8: Each exchange strobe toggles its bit once per rising edge. A strobe held high for several cycles acts once, and no stored value is altered by an exchange.
- R9: In the cycle an exchange strobe rises, reads and writes use the mapping from before the toggle. The new mapping applies from the next cycle.
- R10: When `exDeHl` and `exBank` rise together, the DE/HL toggle applies to the bank that was active before the bank swap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pairSel | input | 3 | Logical pair select code |
| internalAcc | input | 1 | Selects the hidden WZ pair |
| wrLo | input | 1 | Write the low half of the selected pair |
| wrHi | input | 1 | Write the high half of the selected pair |
| wrData | input | 16 | Write data, low byte in bits 7:0 |
| exAf | input | 1 | Accumulator/flag exchange strobe |
| exBank | input | 1 | Bank exchange strobe |
| exDeHl | input | 1 | DE/HL exchange strobe for the active bank |
| rdLo | output | 8 | Low byte of the selected pair |
| rdHi | output | 8 | High byte of the selected pair |

## Verification
An exchange and an access to the renamed pair can fall in the same cycle. The bench raises an exchange strobe while it reads the affected pair, and in one case while it writes to that pair. It then judges that the read showed the old contents and that the write landed in the pair that was visible before the toggle. Bank and DE/HL exchanges are also raised together. A strobe held for several cycles is checked to act only once.

// File: rtl/rf_rename_pkg.sv
package rf_rename_pkg;

  // Physical pair layout
  localparam int PAIR_AF    = 0;   // two entries
  localparam int PAIR_BC    = 2;   // two entries, one per bank
  localparam int PAIR_DEHL  = 4;   // four entries, two per bank
  localparam int PAIR_IX    = 8;
  localparam int PAIR_IY    = 9;
  localparam int PAIR_SP    = 10;
  localparam int PAIR_WZ    = 11;
  localparam int PHYS_PAIRS = 12;
  localparam int IDX_W      = $clog2(PHYS_PAIRS);
  localparam int NUM_STROBES = 3;

  typedef enum logic [2:0] {
    SEL_BC   = 3'd0,
    SEL_DE   = 3'd1,
    SEL_HL   = 3'd2,
    SEL_AF   = 3'd3,
    SEL_IX   = 3'd4,
    SEL_IY   = 3'd5,
    SEL_SP   = 3'd6,
    SEL_NONE = 3'd7
  } pairSel_e;

  // Rename state handed from control to datapath
  typedef struct packed {
    logic       afSel;
    logic       bankSel;
    logic [1:0] dhSel;   // one DE/HL bit per bank
  } renameMap_t;

endpackage

// File: rtl/rf_rename_ctl.sv
module rf_rename_ctl
  import rf_rename_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       exAf,
  input  logic       exBank,
  input  logic       exDeHl,
  output renameMap_t mapQ
);

  logic [NUM_STROBES-1:0] strobeVec;
  logic [NUM_STROBES-1:0] prevQ;
  logic [NUM_STROBES-1:0] edgeVec;

  assign strobeVec = {exDeHl, exBank, exAf};

  // one toggle per rising edge of each strobe
  for (genvar g = 0; g < NUM_STROBES; g++) begin : gEdge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevQ[g] <= 1'b0;
      else       prevQ[g] <= strobeVec[g];
    end
    assign edgeVec[g] = strobeVec[g] & ~prevQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapQ <= '0;
    end else begin
      if (edgeVec[0]) mapQ.afSel   <= ~mapQ.afSel;
      if (edgeVec[1]) mapQ.bankSel <= ~mapQ.bankSel;
      if (edgeVec[2]) mapQ.dhSel[mapQ.bankSel] <= ~mapQ.dhSel[mapQ.bankSel];
    end
  end

  // R8: a held strobe must not toggle again
  p_af_held_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (exAf && prevQ[0]) |=> $stable(mapQ.afSel));

  p_bank_held_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    (exBank && prevQ[1]) |=> $stable(mapQ.bankSel));

  // R5: a fresh edge flips the accumulator pair selection
  p_af_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    (exAf && !prevQ[0]) |=> (mapQ.afSel != $past(mapQ.afSel)));

  // R7, R10: DE/HL toggle leaves the bank that was inactive untouched
  p_dehl_other_bank_r7: assert property (@(posedge clk) disable iff (!rstN)
    (exDeHl && !prevQ[2]) |=>
      (mapQ.dhSel[~$past(mapQ.bankSel)] == $past(mapQ.dhSel[~mapQ.bankSel])));

endmodule

// File: rtl/rf_pair_store.sv
module rf_pair_store
  import rf_rename_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  renameMap_t          mapSel,
  input  logic [2:0]          pairSel,
  input  logic                internalAcc,
  input  logic                wrLo,
  input  logic                wrHi,
  input  logic [2*BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0]   rdLo,
  output logic [BYTE_W-1:0]   rdHi
);

  logic [IDX_W-1:0]  selIdx;
  logic              selValid;
  logic [BYTE_W-1:0] loQ [PHYS_PAIRS];
  logic [BYTE_W-1:0] hiQ [PHYS_PAIRS];
  logic              bank;
  logic              dhBit;

  assign bank  = mapSel.bankSel;
  assign dhBit = mapSel.dhSel[bank];

  // logical name to physical pair
  always_comb begin
    selValid = 1'b1;
    selIdx   = '0;
    if (internalAcc) begin
      selIdx = IDX_W'(PAIR_WZ);
    end else begin
      unique case (pairSel_e'(pairSel))
        SEL_BC: selIdx = IDX_W'(PAIR_BC + int'(bank));
        SEL_DE: selIdx = IDX_W'(PAIR_DEHL + 2 * int'(bank) + (dhBit ? 0 : 1));
        SEL_HL: selIdx = IDX_W'(PAIR_DEHL + 2 * int'(bank) + (dhBit ? 1 : 0));
        SEL_AF: selIdx = IDX_W'(PAIR_AF + int'(mapSel.afSel));
        SEL_IX: selIdx = IDX_W'(PAIR_IX);
        SEL_IY: selIdx = IDX_W'(PAIR_IY);
        SEL_SP: selIdx = IDX_W'(PAIR_SP);
        default: selValid = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < PHYS_PAIRS; g++) begin : gPair
    logic hit;
    assign hit = selValid && (selIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loQ[g] <= '0;
        hiQ[g] <= '0;
      end else begin
        if (wrLo && hit) loQ[g] <= wrData[BYTE_W-1:0];
        if (wrHi && hit) hiQ[g] <= wrData[2*BYTE_W-1:BYTE_W];
      end
    end
  end

  assign rdLo = selValid ? loQ[selIdx] : '0;
  assign rdHi = selValid ? hiQ[selIdx] : '0;

  // R2: a low-half write is visible next cycle on the same physical pair
  p_low_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrLo && selValid) && (selIdx == $past(selIdx)))
      |-> (rdLo == $past(wrData[BYTE_W-1:0])));

  // R3: the unused code reads as zero
  p_none_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!internalAcc && pairSel == 3'd7) |-> (rdLo == '0 && rdHi == '0));

  // R4: the hidden pair only moves under internal access
  p_wz_guard_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(internalAcc && (wrLo || wrHi)) |=>
      ($stable(loQ[PAIR_WZ]) && $stable(hiQ[PAIR_WZ])));

endmodule

// File: rtl/regfile_rename.sv
module regfile_rename
  import rf_rename_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          pairSel,
  input  logic                internalAcc,
  input  logic                wrLo,
  input  logic                wrHi,
  input  logic [2*BYTE_W-1:0] wrData,
  input  logic                exAf,
  input  logic                exBank,
  input  logic                exDeHl,
  output logic [BYTE_W-1:0]   rdLo,
  output logic [BYTE_W-1:0]   rdHi
);

  renameMap_t mapQ;

  rf_rename_ctl uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .exAf   (exAf),
    .exBank (exBank),
    .exDeHl (exDeHl),
    .mapQ   (mapQ)
  );

  rf_pair_store #(.BYTE_W(BYTE_W)) uStore (
    .clk         (clk),
    .rstN        (rstN),
    .mapSel      (mapQ),
    .pairSel     (pairSel),
    .internalAcc (internalAcc),
    .wrLo        (wrLo),
    .wrHi        (wrHi),
    .wrData      (wrData),
    .rdLo        (rdLo),
    .rdHi        (rdHi)
  );

endmodule

// File: tb/tb_regfile_rename.sv
module tb_regfile_rename;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  pairSel = '0;
  logic        internalAcc = 1'b0;
  logic        wrLo = 1'b0;
  logic        wrHi = 1'b0;
  logic [15:0] wrData = '0;
  logic        exAf = 1'b0;
  logic        exBank = 1'b0;
  logic        exDeHl = 1'b0;
  logic [7:0]  rdLo;
  logic [7:0]  rdHi;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  regfile_rename dut (
    .clk(clk), .rstN(rstN), .pairSel(pairSel), .internalAcc(internalAcc),
    .wrLo(wrLo), .wrHi(wrHi), .wrData(wrData), .exAf(exAf), .exBank(exBank),
    .exDeHl(exDeHl), .rdLo(rdLo), .rdHi(rdHi)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        ia;
    logic        wl;
    logic        wh;
    logic [15:0] wd;
    logic        xa;
    logic        xb;
    logic        xd;
    logic        chk;
    logic [3:0]  req;
    logic [15:0] exp;
  } step_t;

  localparam int NSTEP = 62;
  // sel 0 BC 1 DE 2 HL 3 AF 4 IX 5 IY 6 SP 7 none; expected value is the read before the edge
  localparam step_t STEPS [NSTEP] = '{
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd1,16'h0000}, // R1
    '{3'd0,1'b0,1'b1,1'b1,16'h1122,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000}, // R2
    '{3'd1,1'b0,1'b1,1'b1,16'h3344,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd2,1'b0,1'b1,1'b1,16'h5566,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd3,1'b0,1'b1,1'b1,16'h7788,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd4,1'b0,1'b1,1'b1,16'h99AA,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd5,1'b0,1'b1,1'b1,16'hBBCC,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd6,1'b0,1'b1,1'b1,16'hDDEE,1'b0,1'b0,1'b0,1'b1,4'd2,16'h0000},
    '{3'd7,1'b0,1'b1,1'b1,16'hFFFF,1'b0,1'b0,1'b0,1'b1,4'd3,16'h0000}, // R3
    '{3'd0,1'b1,1'b1,1'b1,16'h0F0F,1'b0,1'b0,1'b0,1'b1,4'd4,16'h0000}, // R4
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h1122}, // R3 decode
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h3344},
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h5566},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h7788},
    '{3'd4,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h99AA},
    '{3'd5,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'hBBCC},
    '{3'd6,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'hDDEE},
    '{3'd7,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd3,16'h0000},
    '{3'd3,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd4,16'h0F0F}, // R4
    '{3'd0,1'b0,1'b1,1'b0,16'h00AB,1'b0,1'b0,1'b0,1'b1,4'd2,16'h1122}, // R2 byte
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd2,16'h11AB},
    '{3'd0,1'b0,1'b0,1'b1,16'hCD00,1'b0,1'b0,1'b0,1'b1,4'd2,16'h11AB},
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd2,16'hCDAB},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd9,16'h7788}, // R9
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd5,16'h0000}, // R5
    '{3'd3,1'b0,1'b1,1'b1,16'h1357,1'b0,1'b0,1'b0,1'b1,4'd5,16'h0000},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd5,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd5,16'h7788},
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1,4'd9,16'h5566}, // R9
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'h0000}, // R6
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'h0000},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'h7788},
    '{3'd4,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'h99AA},
    '{3'd0,1'b0,1'b1,1'b1,16'h2468,1'b0,1'b0,1'b0,1'b0,4'd6,16'h0000},
    '{3'd1,1'b0,1'b1,1'b1,16'hA1A1,1'b0,1'b0,1'b0,1'b0,4'd6,16'h0000},
    '{3'd2,1'b0,1'b1,1'b1,16'hB2B2,1'b0,1'b0,1'b0,1'b0,4'd6,16'h0000},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b1,1'b1,4'd9,16'hA1A1}, // R9
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd7,16'hB2B2}, // R7
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd7,16'hA1A1},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1,4'd7,16'hB2B2},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd7,16'h3344},
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd7,16'h5566},
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'hCDAB},
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1,4'd6,16'hCDAB},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd7,16'hB2B2},
    '{3'd0,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd6,16'h2468},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd8,16'h7788}, // R8 held
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd8,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd8,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd8,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd8,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd8,16'h7788},
    '{3'd3,1'b0,1'b1,1'b1,16'h4242,1'b1,1'b0,1'b0,1'b1,4'd9,16'h7788}, // R9 write+swap
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd9,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0,1'b0,1'b1,4'd9,16'h1357},
    '{3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd9,16'h4242},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b1,1'b1,4'd10,16'hB2B2}, // R10
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd10,16'h3344},
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b1,1'b0,1'b1,4'd10,16'h5566},
    '{3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd10,16'hA1A1},
    '{3'd2,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd10,16'hB2B2},
    '{3'd3,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,4'd4,16'h0F0F}  // R4
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d: read %h, expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic ia, input logic wl, input logic wh,
                       input logic [15:0] wd, input logic xa, input logic xb, input logic xd);
    pairSel = s; internalAcc = ia; wrLo = wl; wrHi = wh; wrData = wd;
    exAf = xa; exBank = xb; exDeHl = xd;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      drive(STEPS[i].sel, STEPS[i].ia, STEPS[i].wl, STEPS[i].wh, STEPS[i].wd,
            STEPS[i].xa, STEPS[i].xb, STEPS[i].xd);
      #1;
      if (STEPS[i].chk) check(int'(STEPS[i].req), {rdHi, rdLo}, STEPS[i].exp);
    end

    // R1: reset in the middle of a run clears data and mapping
    @(negedge clk);
    drive(3'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    rstN = 1'b0;
    #1 check(1, {rdHi, rdLo}, 16'h0000);
    @(negedge clk);
    rstN = 1'b1;
    drive(3'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    #1 check(1, {rdHi, rdLo}, 16'h0000);
    @(negedge clk);
    drive(3'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    #1 check(1, {rdHi, rdLo}, 16'h0000);

    // R8: strobe held for five cycles toggles once and moves no data
    @(negedge clk);
    drive(3'd3, 1'b0, 1'b1, 1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      drive(3'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
    end
    @(negedge clk);
    drive(3'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    #1 check(8, {rdHi, rdLo}, 16'h0000);
    @(negedge clk);
    drive(3'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    drive(3'd3, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    #1 check(8, {rdHi, rdLo}, 16'hAAAA);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
      $finish;
    end
  end

endmodule